// File: doc/BRIEF.md
# Dual-Direction Storing Bus Transceiver

This block joins two 18-bit buses, called A and B, with one datapath in each direction. Every bit of every direction owns its own storage element. That element can pass data straight through, keep the value it last took, or take in new data when its capture strobe rises. The A-to-B path and the B-to-A path each have their own pass-through enable, capture strobe and output enable. Each direction picks its mode independently of the other.

Each bus appears as three separate signals: an input vector, an output vector and a drive-enable flag. A pad ring or an on-chip bus fabric combines these into a real shared wire. The drive enable toward B is active high and the drive enable toward A is active low. A flag reports when both sides are enabled at the same time.

The capture strobes are ordinary level inputs. They are sampled with the fast system clock, and a capture happens on the system clock edge where a strobe is seen high after being low at the previous edge.

Top module: `bus_xcvr`

## Requirements
- R1: Both paths are non-inverting and 18 bits wide. The two paths keep separate stored values, so both can carry different data at the same time.
- R2: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle, whatever `ab_cap` does.
- R3: While `ab_le` is 0, if `ab_cap` is 1 at a system clock edge and was 0 at the previous edge, the `a_in` present at that edge is stored. From then on it appears on `b_out`.
- R4: While `ab_le` is 0 and `ab_cap` holds steady at 1 or at 0, `b_out` keeps the stored value. This includes the value passed at the last edge before `ab_le` fell.
- R5: A falling `ab_cap` while `ab_le` is 0 leaves the stored A-to-B value unchanged.
- R6: `b_oe` is 1 exactly when `ab_oe` is 1; a 0 means B is released (high impedance).
- R7: `a_oe` is 1 exactly when `ba_oe_n` is 0; a 1 on `ba_oe_n` releases A.
- R8: The B-to-A path follows R2 to R5, using `ba_le`, `ba_cap`, `b_in` as its source and `a_out` as its output.
- R9: A synchronous active-low `rst_n` clears both stored values to 0 at the clock edge. The drive enables stay under the control of `ab_oe` and `ba_oe_n` during reset.
- R10: `contention` is 1 exactly when `ab_oe` is 1 and `ba_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the capture strobes |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 18 | Data received from bus A |
| a_out | output | 18 | Data to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A, active high |
| b_in | input | 18 | Data received from bus B |
| b_out | output | 18 | Data to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B, active high |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B pass-through enable |
| ab_cap | input | 1 | A-to-B capture strobe |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A pass-through enable |
| ba_cap | input | 1 | B-to-A capture strobe |
| contention | output | 1 | Both buses enabled at once |

## Verification
Pass-through data, both drive enables and the contention flag are combinational, so they are valid in the same cycle as their inputs. A capture, a reset clear, and the value held after a pass-through phase ends all show up after exactly one system clock edge. The bench therefore drives each stimulus at a falling clock edge, lets one rising edge pass, and checks at the next falling edge. Its expected values come from a mode-table model that the bench advances once per applied stimulus.

// File: rtl/xcvr_pkg.sv
// Package: shared mode type and decode for the storing transceiver.
// Assumes the capture-strobe edge has already been detected on the system clock.
package xcvr_pkg;

    typedef enum logic [1:0] {
        MODE_PASS    = 2'd0,
        MODE_HOLD    = 2'd1,
        MODE_CAPTURE = 2'd2
    } path_mode_e;

    // Chooses the storage action for one direction in the current cycle.
    function automatic path_mode_e decode_mode(input logic le, input logic rise);
        if (le)
            return MODE_PASS;
        else if (rise)
            return MODE_CAPTURE;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_edge_detect.sv
// Module: detects a rising level on a capture strobe sampled by the system clock.
// Assumes the strobe is already synchronous to clk. The previous-level register
// keeps sampling during reset, so a strobe that is high across reset release is
// not seen as a rising edge.
module xcvr_edge_detect (
    input  logic clk,
    input  logic strobe,
    output logic rise
);

    logic strobe_q;

    // Remember the level seen at the last system clock edge.
    always_ff @(posedge clk) begin
        strobe_q <= strobe;
    end

    // Rising edge: high now, low at the previous edge.
    always_comb begin
        rise = strobe & ~strobe_q;
    end

endmodule

// File: rtl/xcvr_store.sv
// Module: one direction's per-bit storage bank with a pass-through output mux.
// Assumes the mode is decoded from the same-cycle pass enable and edge flag.
module xcvr_store #(
    parameter int WIDTH = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  xcvr_pkg::path_mode_e     mode,
    input  logic [WIDTH-1:0]         din,
    output logic [WIDTH-1:0]         dout
);
    import xcvr_pkg::*;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic cell_q;

            // Load the bit when passing or capturing; clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cell_q <= 1'b0;
                else if (mode != MODE_HOLD)
                    cell_q <= din[gi];
            end

            // Output is the live input when passing, else the stored bit.
            always_comb begin
                dout[gi] = (mode == MODE_PASS) ? din[gi] : cell_q;
            end
        end
    endgenerate

endmodule

// File: rtl/xcvr_path.sv
// Module: a complete one-direction path made of edge detect, mode decode and storage.
// Assumes all controls are synchronous to clk.
module xcvr_path #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic             cap,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    import xcvr_pkg::*;

    logic       cap_rise;
    path_mode_e mode;

    xcvr_edge_detect u_edge (
        .clk    (clk),
        .strobe (cap),
        .rise   (cap_rise)
    );

    // Pick pass, capture or hold for this cycle.
    always_comb begin
        mode = decode_mode(le, cap_rise);
    end

    xcvr_store #(.WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .din   (din),
        .dout  (dout)
    );

endmodule

// File: rtl/bus_xcvr.sv
// Module: top of the two-direction storing bus transceiver.
// Assumes the buses are split into input, output and drive-enable signals
// that are resolved outside this block.
module bus_xcvr #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             ab_oe,
    input  logic             ab_le,
    input  logic             ab_cap,
    input  logic             ba_oe_n,
    input  logic             ba_le,
    input  logic             ba_cap,
    output logic             contention
);

    xcvr_path #(.WIDTH(WIDTH)) u_ab (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (ab_le),
        .cap   (ab_cap),
        .din   (a_in),
        .dout  (b_out)
    );

    xcvr_path #(.WIDTH(WIDTH)) u_ba (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (ba_le),
        .cap   (ba_cap),
        .din   (b_in),
        .dout  (a_out)
    );

    // Drive enables with their opposite polarities, and the both-driving flag.
    always_comb begin
        b_oe       = ab_oe;
        a_oe       = ~ba_oe_n;
        contention = ab_oe & ~ba_oe_n;
    end

endmodule

// File: rtl/bus_xcvr_chk.sv
// Module: assertion checker bound to the transceiver top.
// Assumes it sees only the top's ports; it keeps its own copies of the strobe levels.
module bus_xcvr_chk #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic             ab_oe,
    input logic             ab_le,
    input logic             ab_cap,
    input logic             ba_oe_n,
    input logic             ba_le,
    input logic             ba_cap,
    input logic             contention
);

    logic ab_cap_q, ba_cap_q;

    // Checker's own record of the strobe levels at the last edge.
    always_ff @(posedge clk) begin
        ab_cap_q <= ab_cap;
        ba_cap_q <= ba_cap;
    end

    AST_AB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le |-> (b_out == a_in)); // R2

    AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && ab_cap && !ab_cap_q) |=> (ab_le || b_out == $past(a_in))); // R3

    AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !(ab_cap && !ab_cap_q)) |=> (ab_le || $stable(b_out))); // R4

    AST_BA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le |-> (a_out == b_in)); // R8

    AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && ba_cap && !ba_cap_q) |=> (ba_le || a_out == $past(b_in))); // R8

    AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && !(ba_cap && !ba_cap_q)) |=> (ba_le || $stable(a_out))); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        (!rst_n && !ab_le && !ba_le) |=> (ab_le || b_out == '0)); // R9

    AST_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        contention |-> (a_oe && b_oe)); // R10

endmodule

bind bus_xcvr bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/bus_xcvr_tb_top.sv
// Bench: table-driven walk of the mode sequence, then directed reset,
// enable, contention and random mode-table comparisons.
module bus_xcvr_tb_top;

    localparam int W        = 18;
    localparam int CLK_PER  = 10;
    localparam int WATCHDOG = 20000;
    localparam logic [W-1:0] MASK = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, contention;
    logic         ab_oe = 1'b0, ab_le = 1'b0, ab_cap = 1'b0;
    logic         ba_oe_n = 1'b1, ba_le = 1'b0, ba_cap = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model of each direction's stored value and last strobe level.
    logic [W-1:0] ref_ab = '0, ref_ba = '0;
    logic         pcap_ab = 1'b0, pcap_ba = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    bus_xcvr #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_oe(ab_oe), .ab_le(ab_le), .ab_cap(ab_cap),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_cap(ba_cap),
        .contention(contention)
    );

    // Vector: {le, cap, data, expected output after one edge}
    localparam int NV = 10;
    localparam logic [2*W+1:0] VEC [NV] = '{
        {1'b1, 1'b0, 18'h11111, 18'h11111},
        {1'b0, 1'b0, 18'h22222, 18'h11111},
        {1'b0, 1'b1, 18'h33333, 18'h33333},
        {1'b0, 1'b1, 18'h04444, 18'h33333},
        {1'b0, 1'b0, 18'h05555, 18'h33333},
        {1'b0, 1'b0, 18'h06666, 18'h33333},
        {1'b1, 1'b1, 18'h2ABCD, 18'h2ABCD},
        {1'b0, 1'b1, 18'h00001, 18'h2ABCD},
        {1'b0, 1'b0, 18'h3FFFF, 18'h2ABCD},
        {1'b0, 1'b1, 18'h3FFFF, 18'h3FFFF}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one stimulus at a falling edge, advance the model, check one edge later.
    task automatic step(input logic le1, input logic c1, input logic [W-1:0] d1,
                        input logic le2, input logic c2, input logic [W-1:0] d2,
                        input string req);
        logic [W-1:0] e1, e2;
        logic r1, r2;
        ab_le = le1; ab_cap = c1; a_in = d1;
        ba_le = le2; ba_cap = c2; b_in = d2;
        r1 = c1 & ~pcap_ab;
        r2 = c2 & ~pcap_ba;
        if (le1 || r1) ref_ab = d1;
        if (le2 || r2) ref_ba = d2;
        pcap_ab = c1;
        pcap_ba = c2;
        e1 = le1 ? d1 : ref_ab;
        e2 = le2 ? d2 : ref_ba;
        @(posedge clk);
        @(negedge clk);
        check({req, " b_out"}, b_out, e1);
        check({req, " a_out"}, a_out, e2);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9: reset cleared both banks
        check("R9 reset b_out", b_out, '0);
        check("R9 reset a_out", a_out, '0);
        // R9: enables follow their inputs during reset
        ab_oe = 1'b1; ba_oe_n = 1'b0;
        #1;
        check("R9 b_oe in reset", {{(W-1){1'b0}}, b_oe}, 18'd1);
        check("R9 a_oe in reset", {{(W-1){1'b0}}, a_oe}, 18'd1);
        ab_oe = 1'b0; ba_oe_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 R3 R4 R5 on A-to-B, R8 on B-to-A with inverted data (R1)
        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] ex;
            ex = VEC[i][W-1:0];
            step(VEC[i][2*W+1], VEC[i][2*W], VEC[i][2*W-1:W],
                 VEC[i][2*W+1], VEC[i][2*W], ~VEC[i][2*W-1:W] & MASK,
                 "R2/R3/R4/R5/R8 table");
            check("R1 table b_out vs vector", b_out, ex);
            check("R8 table a_out vs vector", a_out, ~ex & MASK);
        end

        // R1: independent directions, one passing, the other holding
        step(1'b1, 1'b0, 18'h0F0F0, 1'b0, 1'b0, 18'h12345, "R1 independent");
        check("R1 held B-to-A", a_out, ~18'h3FFFF & MASK);

        // R5: falling strobe with pass disabled keeps the value
        step(1'b0, 1'b1, 18'h00AAA, 1'b0, 1'b1, 18'h00BBB, "R3 capture");
        step(1'b0, 1'b0, 18'h15555, 1'b0, 1'b0, 18'h16666, "R5 fall");
        check("R5 b_out after fall", b_out, 18'h00AAA);

        // R6, R7, R10: enable polarities and contention over all four combinations
        for (int k = 0; k < 4; k++) begin
            ab_oe = k[0]; ba_oe_n = k[1];
            #1;
            check("R6 b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, k[0]});
            check("R7 a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, ~k[1]});
            check("R10 contention", {{(W-1){1'b0}}, contention},
                  {{(W-1){1'b0}}, (k[0] & ~k[1])});
        end
        ab_oe = 1'b1; ba_oe_n = 1'b0;

        // Random mode sequences against the model: R2 R3 R4 R5 R8
        for (int n = 0; n < 300; n++) begin
            step($urandom_range(0, 3) == 0, 1'($urandom), 18'($urandom),
                 $urandom_range(0, 3) == 0, 1'($urandom), 18'($urandom),
                 "R4/R8 random");
        end

        // R9: reset mid-run clears stored values
        step(1'b1, 1'b0, 18'h2F00D, 1'b1, 1'b0, 18'h1BEEF, "R2 pre-reset");
        ab_le = 1'b0; ba_le = 1'b0; rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ref_ab = '0; ref_ba = '0;
        check("R9 mid-run b_out", b_out, '0);
        check("R9 mid-run a_out", a_out, '0);
        step(1'b0, 1'b0, 18'h12121, 1'b0, 1'b0, 18'h23232, "R9 held after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule